// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block applies one saturating integer operation to every lane of a packed vector in a single step. A vector is 128 bits wide, or 64 bits when the half-width mode is selected. Lanes are 8, 16, 32 or 64 bits. The operations are add and subtract, in signed or unsigned form, plus signed absolute value and signed negate. Every lane is clamped on its own to the bound of its type.

A narrowing move halves the width of each lane. It has three variants: signed to signed, unsigned to unsigned, and signed to unsigned. Each variant saturates values that do not fit, and the narrowed lanes are packed into the low half of the result.

Any lane that clamps sets one sticky saturation flag. The flag stays set over later operations until software pulses the clear input. The result, the flag update and a result-valid strobe all appear one clock after the input strobe.

Top module: `sat_lane_alu`

## Requirements
- R1: Unsigned add (op_sel=0, signed_mode=0): a lane whose wrapped sum is less than either operand returns all ones and saturates; otherwise it returns the sum.
- R2: Unsigned subtract (op_sel=1, signed_mode=0): a lane whose wrapped difference exceeds the minuend returns zero and saturates.
- R3: Signed add or subtract (signed_mode=1) saturates when the sign of the result disagrees with the operand signs. The lane then clamps to the most positive value of its width when the first operand is non-negative, and to the most negative value otherwise.
- R4: Absolute value (op_sel=2) and negate (op_sel=3) always treat lanes as signed and ignore signed_mode and src_b. A lane holding the most negative value returns its bitwise inverse, which is the most positive value, and saturates.
- R5: Signed narrow (op_sel=4, signed_mode=1): lane_sz gives the source lane size (1=16, 2=32, 3=64). The low half is kept when it sign-extends back to the source; otherwise the lane clamps to the narrow maximum magnitude with the source's sign and saturates.
- R6: Unsigned narrow (op_sel=4, signed_mode=0): a source lane whose upper half is nonzero returns all ones in the narrow width and saturates.
- R7: Signed-to-unsigned narrow (op_sel=5, signed_mode ignored): a negative source returns zero and a source too large for the narrow width returns all ones, and both cases saturate.
- R8: sat_flag is sticky. Only a cycle with in_valid high can set it, and no operation ever clears it.
- R9: A sat_clear pulse clears sat_flag at the next edge. If a saturating valid operation arrives in the same cycle, the flag ends up set.
- R10: With full_width=0, only src bits [63:0] take part. The upper 64 result bits are zero and upper-lane inputs cannot saturate.
- R11: result and sat_flag update at the first rising edge after in_valid, and out_valid is high for exactly that one cycle. After reset the result is zero, out_valid is low and the flag is clear. The result is held while in_valid is low.
- R12: A narrow with lane_sz=0 (8-bit source), and the unused op codes 6 and 7, return zero and do not saturate.
- R13: Narrowed lanes are packed in order from bit 0: source lane i lands at narrow position i of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | 0 add, 1 sub, 2 abs, 3 neg, 4 narrow, 5 signed-to-unsigned narrow |
| lane_sz | input | 2 | Lane size 0=8, 1=16, 2=32, 3=64 bits (source size for narrows) |
| signed_mode | input | 1 | Signed interpretation for add, sub and narrow |
| full_width | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| sat_clear | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result-valid strobe |
| result | output | 128 | Registered result vector |
| sat_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
The bench builds the block with the default 128-bit vector, so all four lane-size slices and both narrow packings are present. At that width the 64-bit lanes reach their signed extremes, and half-width mode can be driven with all-ones upper halves that would saturate if they leaked through. The vectors place the most negative and most positive values at every lane size, and they also cover the clear-versus-set collision on the flag.

// File: rtl/sat_lane_pkg.sv
package sat_lane_pkg;

   typedef enum logic [2:0] {
      OP_ADD       = 3'd0,
      OP_SUB       = 3'd1,
      OP_ABS       = 3'd2,
      OP_NEG       = 3'd3,
      OP_NARROW    = 3'd4,
      OP_NARROW_SU = 3'd5
   } sat_op_e;

   localparam int NUM_SIZES = 4;
   localparam int MIN_LANE  = 8;

endpackage

// File: rtl/sat_lane_unit.sv
module sat_lane_unit
   import sat_lane_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  sat_op_e      op,
   input  logic         is_signed,
   output logic [W-1:0] res,
   output logic         sat
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] sum, dif, neg_a;
   logic         a_is_min;

   assign sum      = a + b;
   assign dif      = a - b;
   assign neg_a    = '0 - a;
   assign a_is_min = (a == SMIN);

   always_comb begin
      res = '0;
      sat = 1'b0;
      case (op)
         OP_ADD: begin
            if (is_signed) begin
               sat = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
               res = sat ? (a[W-1] ? SMIN : SMAX) : sum;
            end else begin
               sat = (sum < a) || (sum < b);
               res = sat ? '1 : sum;
            end
         end
         OP_SUB: begin
            if (is_signed) begin
               sat = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
               res = sat ? (a[W-1] ? SMIN : SMAX) : dif;
            end else begin
               sat = (dif > a);
               res = sat ? '0 : dif;
            end
         end
         OP_ABS: begin
            sat = a_is_min;
            res = a_is_min ? ~a : (a[W-1] ? neg_a : a);
         end
         OP_NEG: begin
            sat = a_is_min;
            res = a_is_min ? ~a : neg_a;
         end
         default: begin
            res = '0;
            sat = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit #(
   parameter int SW = 16
) (
   input  logic [SW-1:0]   a,
   input  logic            signed_src,
   input  logic            to_unsigned,
   output logic [SW/2-1:0] res,
   output logic            sat
);
   localparam int NW = SW / 2;
   localparam logic [NW-1:0] NMAX = {1'b0, {(NW-1){1'b1}}};
   localparam logic [NW-1:0] NMIN = {1'b1, {(NW-1){1'b0}}};

   logic [NW-1:0] lo, hi;
   assign lo = a[NW-1:0];
   assign hi = a[SW-1:NW];

   always_comb begin
      res = lo;
      sat = 1'b0;
      if (to_unsigned) begin
         if (a[SW-1]) begin
            res = '0;
            sat = 1'b1;
         end else if (hi != '0) begin
            res = '1;
            sat = 1'b1;
         end
      end else if (signed_src) begin
         if (hi != {NW{lo[NW-1]}}) begin
            res = a[SW-1] ? NMIN : NMAX;
            sat = 1'b1;
         end
      end else if (hi != '0) begin
         res = '1;
         sat = 1'b1;
      end
   end
endmodule

// File: rtl/sat_vec_slice.sv
module sat_vec_slice
   import sat_lane_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int W     = 8
) (
   input  logic [VEC_W-1:0]   a,
   input  logic [VEC_W-1:0]   b,
   input  sat_op_e            op,
   input  logic               is_signed,
   input  logic               half_mode,
   output logic [VEC_W-1:0]   res,
   output logic               sat,
   output logic [VEC_W/2-1:0] nres,
   output logic               nsat
);
   localparam int N     = VEC_W / W;
   localparam int NHALF = N / 2;
   localparam int NW    = W / 2;

   logic [N-1:0] lane_sat;
   logic [N-1:0] lane_act;

   for (genvar i = 0; i < N; i++) begin : g_lane
      logic s_raw;
      assign lane_act[i] = !half_mode || (i < NHALF);
      sat_lane_unit #(.W(W)) u_lane (
         .a         (a[i*W +: W]),
         .b         (b[i*W +: W]),
         .op        (op),
         .is_signed (is_signed),
         .res       (res[i*W +: W]),
         .sat       (s_raw)
      );
      assign lane_sat[i] = s_raw & lane_act[i];
   end

   assign sat = |lane_sat;

   if (W >= 2 * MIN_LANE) begin : g_narrow
      logic [N-1:0] nlane_sat;
      for (genvar i = 0; i < N; i++) begin : g_nl
         logic ns_raw;
         sat_narrow_unit #(.SW(W)) u_nar (
            .a           (a[i*W +: W]),
            .signed_src  (is_signed),
            .to_unsigned (op == OP_NARROW_SU),
            .res         (nres[i*NW +: NW]),
            .sat         (ns_raw)
         );
         assign nlane_sat[i] = ns_raw & lane_act[i];
      end
      assign nsat = |nlane_sat;
   end else begin : g_no_narrow
      assign nres = '0;
      assign nsat = 1'b0;
   end
endmodule

// File: rtl/sat_lane_alu.sv
module sat_lane_alu
   import sat_lane_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [2:0]       op_sel,
   input  logic [1:0]       lane_sz,
   input  logic             signed_mode,
   input  logic             full_width,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             sat_clear,
   output logic             out_valid,
   output logic [VEC_W-1:0] result,
   output logic             sat_flag
);
   localparam int HALF_W = VEC_W / 2;

   if (VEC_W % 128 != 0) begin : g_bad_width
      $error("sat_lane_alu: VEC_W must be a multiple of 128");
   end

   sat_op_e          op_e;
   logic [VEC_W-1:0] a_eff, b_eff;
   logic [VEC_W-1:0] s_res  [NUM_SIZES];
   logic [HALF_W-1:0] s_nres [NUM_SIZES];
   logic [NUM_SIZES-1:0] s_sat, s_nsat;
   logic [VEC_W-1:0] sel_res;
   logic             sel_sat;

   assign op_e  = sat_op_e'(op_sel);
   assign a_eff = full_width ? src_a : {{HALF_W{1'b0}}, src_a[HALF_W-1:0]};
   assign b_eff = full_width ? src_b : {{HALF_W{1'b0}}, src_b[HALF_W-1:0]};

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      sat_vec_slice #(.VEC_W(VEC_W), .W(MIN_LANE << k)) u_slice (
         .a         (a_eff),
         .b         (b_eff),
         .op        (op_e),
         .is_signed (signed_mode),
         .half_mode (!full_width),
         .res       (s_res[k]),
         .sat       (s_sat[k]),
         .nres      (s_nres[k]),
         .nsat      (s_nsat[k])
      );
   end

   always_comb begin
      sel_res = '0;
      sel_sat = 1'b0;
      case (op_e)
         OP_ADD, OP_SUB, OP_ABS, OP_NEG: begin
            sel_res = s_res[lane_sz];
            sel_sat = s_sat[lane_sz];
         end
         OP_NARROW, OP_NARROW_SU: begin
            sel_res = {{HALF_W{1'b0}}, s_nres[lane_sz]};
            sel_sat = s_nsat[lane_sz];
         end
         default: begin
            sel_res = '0;
            sel_sat = 1'b0;
         end
      endcase
      if (!full_width) sel_res[VEC_W-1:HALF_W] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= sel_res;
         sat_flag <= (sat_flag & ~sat_clear) | (in_valid & sel_sat);
      end
   end

   AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                        // R11
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                      // R11
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));                                 // R11
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clear) |=> sat_flag);                         // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sel_sat) |=> sat_flag);                            // R9
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_clear && !(in_valid && sel_sat)) |=> !sat_flag);           // R9
   AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !full_width) |=> (result[VEC_W-1:HALF_W] == '0));  // R10
endmodule

// File: tb/sat_lane_alu_tb.sv
`timescale 1ns/100ps
module sat_lane_alu_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [2:0]   op_sel = '0;
   logic [1:0]   lane_sz = '0;
   logic         signed_mode = 1'b0;
   logic         full_width = 1'b0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         sat_clear = 1'b0;
   logic         out_valid;
   logic [127:0] result;
   logic         sat_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   sat_lane_alu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .lane_sz(lane_sz), .signed_mode(signed_mode), .full_width(full_width),
      .src_a(src_a), .src_b(src_b), .sat_clear(sat_clear),
      .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
   );

   localparam int NV = 15;
   localparam logic [2:0] T_OP [NV] = '{0,0,0,1,1,2,3,0,0,4,4,5,5,0,4};
   localparam logic [1:0] T_SZ [NV] = '{0,0,1,1,2,1,0,3,3,1,2,3,1,0,0};
   localparam logic       T_SG [NV] = '{0,1,0,0,1,0,1,1,0,1,0,0,0,0,1};
   localparam logic       T_FW [NV] = '{0,0,0,0,0,0,0,1,1,0,1,1,0,0,1};
   localparam logic [127:0] T_A [NV] = '{
      128'h0010FF8001FE7F00,                      // R1 u8 add
      128'h0010FF8001FE7F00,                      // R3 s8 add
      128'h123400017FFF8000,                      // R1 u16 add, no clamp
      128'h00050000FFFF1000,                      // R2 u16 sub
      128'h800000007FFFFFFF,                      // R3 s32 sub
      128'h8000FFFF00058001,                      // R4 abs
      128'h800100FF7F8102FE,                      // R4 neg
      128'h7FFFFFFFFFFFFFFF_0000000000000005,     // R3 s64 add
      128'h0000000000000001_FFFFFFFF00000000,     // R1 u64 add
      128'h007FFF800100FE00,                      // R5 R13 signed narrow
      128'h00000001_0000FFFF_00010000_FFFFFFFF,   // R6 unsigned narrow
      128'hFFFFFFFFFFFFFFFF_0000000012345678,     // R7 s->u narrow
      128'h00FF000000800001,                      // R7 s->u no clamp
      128'hFFFFFFFFFFFFFFFF_0000000000000001,     // R10 upper ignored
      128'hFFFFFFFFFFFFFFFF_0000000000001234};    // R12 8-bit narrow
   localparam logic [127:0] T_B [NV] = '{
      128'h00200180FE010100, 128'h00200180FE010100, 128'h0001FFFE00017FFF,
      128'h00030001FFFF2000, 128'h00000001FFFFFFFF, 128'h0, 128'h0,
      128'h0000000000000001_0000000000000003,
      128'h0000000000000002_00000000FFFFFFFF,
      128'h0, 128'h0, 128'h0, 128'h0,
      128'hFFFFFFFFFFFFFFFF_0000000000000001, 128'h0};
   localparam logic [127:0] T_EXP [NV] = '{
      128'h0030FFFFFFFF8000, 128'h00300080FFFF7F00, 128'h1235FFFF8000FFFF,
      128'h0002000000000000, 128'h800000007FFFFFFF, 128'h7FFF000100057FFF,
      128'h7FFF0001817FFE02,
      128'h7FFFFFFFFFFFFFFF_0000000000000008,
      128'h0000000000000003_FFFFFFFFFFFFFFFF,
      128'h7F807F80, 128'h0001FFFFFFFFFFFF, 128'h0000000012345678,
      128'hFF008001, 128'h2, 128'h0};
   localparam logic T_SAT [NV] = '{1,1,0,1,1,1,1,1,0,1,1,1,0,0,0};
   localparam int   T_REQ [NV] = '{1,3,1,2,3,4,4,3,1,5,6,7,7,10,12};

   task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, got, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic sg,
                        input logic fw, input logic [127:0] a, input logic [127:0] b,
                        input logic clr);
      @(negedge clk);
      op_sel = op; lane_sz = sz; signed_mode = sg; full_width = fw;
      src_a = a; src_b = b; sat_clear = clr; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; sat_clear = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      sat_clear = 1'b1;
      @(negedge clk);
      sat_clear = 1'b0;
   endtask

   initial begin : watchdog
      #500000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 reset result", result, '0);
      check("R11 reset out_valid", {127'b0, out_valid}, 128'h0);
      check("R11 reset flag", {127'b0, sat_flag}, 128'h0);

      for (int i = 0; i < NV; i++) begin
         clear_flag();
         issue(T_OP[i], T_SZ[i], T_SG[i], T_FW[i], T_A[i], T_B[i], 1'b0);
         check($sformatf("R%0d vec%0d result", T_REQ[i], i), result, T_EXP[i]);
         check($sformatf("R%0d vec%0d flag", T_REQ[i], i), {127'b0, sat_flag}, {127'b0, T_SAT[i]});
         check($sformatf("R11 vec%0d out_valid", i), {127'b0, out_valid}, 128'h1);
      end

      // R11 out_valid lasts one cycle
      @(negedge clk);
      check("R11 out_valid drops", {127'b0, out_valid}, 128'h0);

      // R8 sticky: saturate, then a clean op keeps the flag
      clear_flag();
      issue(3'd0, 2'd0, 1'b0, 1'b0, T_A[0], T_B[0], 1'b0);
      issue(3'd0, 2'd1, 1'b0, 1'b0, T_A[2], T_B[2], 1'b0);
      check("R8 clean op result", result, T_EXP[2]);
      check("R8 flag stays set", {127'b0, sat_flag}, 128'h1);

      // R9 clear alone
      clear_flag();
      check("R9 clear", {127'b0, sat_flag}, 128'h0);

      // R8 R11 saturating inputs without in_valid are ignored
      @(negedge clk);
      op_sel = 3'd0; lane_sz = 2'd0; src_a = T_A[0]; src_b = T_B[0]; full_width = 1'b0;
      @(negedge clk);
      check("R8 no set without valid", {127'b0, sat_flag}, 128'h0);
      check("R11 result held", result, T_EXP[2]);

      // R9 clear and set together: set wins
      sat_flag_set_wins: begin
         issue(3'd0, 2'd0, 1'b0, 1'b0, T_A[0], T_B[0], 1'b1);
         check("R9 set wins", {127'b0, sat_flag}, 128'h1);
      end

      // R12 unused op code
      clear_flag();
      issue(3'd6, 2'd2, 1'b1, 1'b1, {4{32'h80000000}}, {4{32'h80000000}}, 1'b0);
      check("R12 op6 result", result, '0);
      check("R12 op6 flag", {127'b0, sat_flag}, 128'h0);

      // R4 abs ignores signed_mode and src_b, full width 8-bit lanes
      clear_flag();
      issue(3'd2, 2'd0, 1'b0, 1'b1, {16{8'h80}}, {16{8'h7F}}, 1'b0);
      check("R4 abs all min", result, {16{8'h7F}});
      check("R4 abs flag", {127'b0, sat_flag}, 128'h1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule